// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block connects a processor bus to a small bank of internal registers that sit in a slow timekeeping domain. The host sees only two registers. The first is an address/control register. The second is a data window. Software picks an internal slot through the address field and then moves a byte through the data window. The bridge turns each move into an indirect read or write strobe. The strobe width is chosen by a timing-select bit.

While a transfer is running, the bridge raises a busy flag. After an access to a multi-byte capture or alarm group, the slot address steps forward. Because of this, software can walk a whole group without rewriting the address. When auto-read is enabled, each host read of the data window starts the next indirect read. A group can then be streamed with one data read per byte.

The internal bank here is a plain model with sixteen byte-wide slots. It exists so that the sequencing and addressing can be exercised from end to end.

Top module: `irb_bridge`

## Requirements
- R1: After reset, the address/control register reads 0x00, the data window reads 0x00 and every internal slot holds 0x00.
- R2: Reading the address/control register returns busy in bit 7, auto-read in bit 6, a spare stored bit in bit 5, short timing in bit 4 and the slot address in bits 3..0. Bits 6..0 read back as last written. The spare bit has no effect on any transfer.
- R3: Writing the address/control register with bit 7 = 1 starts an indirect read of the slot named by the written address. When the read completes, the data window holds that slot's contents.
- R4: Writing the data window while idle loads it and starts an indirect write of that byte into the addressed slot.
- R5: Busy reads 1 for exactly 4 clock cycles per transfer when short timing is 0, and for exactly 1 cycle when it is 1. After that it reads 0.
- R6: When auto-read is 1, a host read of the data window while idle starts the next indirect read. When auto-read is 0, such a read starts nothing.
- R7: After a transfer to slot 0..5 (capture group) or slot 8..13 (alarm group), the address increments by one. After a transfer to any other slot, the address is unchanged. This means slot 5 steps to 6 and then stays at 6.
- R8: While busy is 1, host writes to either register are ignored. The data window, the address and the running transfer are unaffected.
- R9: Slots 6 (control), 7 (extended control), 14 (RAM address) and 15 (RAM data) are byte storage just like the capture and alarm slots. Each of the sixteen slots returns the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Register select: 0 address/control, 1 data window |
| hostWr | input | 1 | Host write strobe for the selected register |
| hostRd | input | 1 | Host read strobe (triggers auto-read on the data window) |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Contents of the selected register |

## Verification
The bench uses the default build: byte-wide data, a 4-bit slot address, a long strobe of 4 clocks, and capture and alarm groups of six slots at bases 0 and 8.

At this size, all sixteen slots can be swept. Each slot is written with a distinct arithmetic pattern, alternating strobe widths, and then read back. The bench therefore reaches every group boundary where auto-increment starts or stops. It also covers an auto-read chain that runs off the end of the capture group, and writes made during a long strobe.

// File: rtl/irb_pkg.sv
package irb_pkg;

  typedef struct packed {
    logic loadCtrl;    // idle host write to address/control
    logic loadData;    // idle host write to data window
    logic startRd;     // begin an indirect read
    logic startWr;     // begin an indirect write
    logic finish;      // last strobe cycle of the running transfer
    logic finishRead;  // finish of a read transfer
  } ctlStrobes_t;

  function automatic logic inGroup(input logic [7:0] a, input int capBase,
                                    input int almBase, input int grpLen);
    int v;
    v = int'(a);
    return ((v >= capBase) && (v < capBase + grpLen)) ||
           ((v >= almBase) && (v < almBase + grpLen));
  endfunction

endpackage

// File: rtl/irb_ctrl.sv
module irb_ctrl
  import irb_pkg::*;
#(
  parameter int LONG_STROBE = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic        wdStart,
  input  logic        wdShort,
  input  logic        autoRd,
  input  logic        shortMode,
  output ctlStrobes_t ctl,
  output logic        busy
);

  localparam int CNT_W = $clog2(LONG_STROBE + 1);

  logic [CNT_W-1:0] cnt;
  logic             isRead;
  logic             idleCtrlWr;
  logic             useShort;
  logic             startAny;

  always_comb begin
    idleCtrlWr     = hostWr && !hostSel && !busy;
    ctl.loadCtrl   = idleCtrlWr;
    ctl.loadData   = hostWr && hostSel && !busy;
    ctl.startWr    = ctl.loadData;
    ctl.startRd    = (idleCtrlWr && wdStart) ||
                     (hostRd && hostSel && !hostWr && autoRd && !busy);
    ctl.finish     = busy && (cnt == '0);
    ctl.finishRead = ctl.finish && isRead;
    useShort       = idleCtrlWr ? wdShort : shortMode;
    startAny       = ctl.startRd || ctl.startWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      isRead <= 1'b0;
    end else if (startAny) begin
      busy   <= 1'b1;
      isRead <= ctl.startRd;
      cnt    <= useShort ? '0 : CNT_W'(LONG_STROBE - 1);
    end else if (ctl.finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startAny |=> busy); // R5
  AST_SHORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (startAny && useShort) |=> ctl.finish); // R5
  AST_LONG_NOT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (startAny && !useShort) |=> (busy && !ctl.finish)); // R5
  AST_FINISH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> !busy); // R5

endmodule

// File: rtl/irb_datapath.sv
module irb_datapath
  import irb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int CAP_BASE = 0,
  parameter int ALM_BASE = 8,
  parameter int GRP_LEN  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              busy,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              autoRd,
  output logic              shortMode
);

  localparam int DEPTH = 1 << ADDR_W;

  logic              spareBit;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] bank [DEPTH];
  logic [DATA_W-1:0] slotOut;
  logic              grp;
  logic [DATA_W-1:0] ctrlView;

  always_comb begin
    grp      = inGroup(8'(addr), CAP_BASE, ALM_BASE, GRP_LEN);
    slotOut  = bank[addr];
    ctrlView = '0;
    ctrlView[7]          = busy;
    ctrlView[6]          = autoRd;
    ctrlView[5]          = spareBit;
    ctrlView[4]          = shortMode;
    ctrlView[ADDR_W-1:0] = addr;
    hostRdata = hostSel ? dataReg : ctrlView;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoRd    <= 1'b0;
      spareBit  <= 1'b0;
      shortMode <= 1'b0;
    end else if (ctl.loadCtrl) begin
      autoRd    <= hostWdata[6];
      spareBit  <= hostWdata[5];
      shortMode <= hostWdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 addr <= '0;
    else if (ctl.loadCtrl)     addr <= hostWdata[ADDR_W-1:0];
    else if (ctl.finish && grp) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               dataReg <= '0;
    else if (ctl.loadData)   dataReg <= hostWdata;
    else if (ctl.finishRead) dataReg <= slotOut;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        bank[s] <= '0;
      else if (ctl.finish && !ctl.finishRead && (addr == ADDR_W'(s)))
        bank[s] <= dataReg;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && grp) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && !grp) |=> $stable(addr)); // R7
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWr && !ctl.finishRead) |=> ($stable(dataReg) && $stable(shortMode))); // R8
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishRead |=> (dataReg == $past(slotOut))); // R3

endmodule

// File: rtl/irb_bridge.sv
module irb_bridge
  import irb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int LONG_STROBE = 4,
  parameter int CAP_BASE    = 0,
  parameter int ALM_BASE    = 8,
  parameter int GRP_LEN     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata
);

  ctlStrobes_t ctl;
  logic        busy;
  logic        autoRd;
  logic        shortMode;

  irb_ctrl #(.LONG_STROBE(LONG_STROBE)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .wdStart   (hostWdata[7]),
    .wdShort   (hostWdata[4]),
    .autoRd    (autoRd),
    .shortMode (shortMode),
    .ctl       (ctl),
    .busy      (busy)
  );

  irb_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CAP_BASE (CAP_BASE),
    .ALM_BASE (ALM_BASE),
    .GRP_LEN  (GRP_LEN)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busy      (busy),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .autoRd    (autoRd),
    .shortMode (shortMode)
  );

endmodule

// File: tb/irb_bridge_test.sv
module irb_bridge_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSel = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  irb_bridge uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic int nextAddr(input int a);
    if ((a <= 5) || (a >= 8 && a <= 13)) return (a + 1) & 15;
    return a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    hostSel = sel; hostWr = 1'b1; hostWdata = val;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rdReg(input logic sel, output logic [7:0] val);
    @(negedge clk);
    hostSel = sel; hostRd = 1'b1;
    #1 val = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic peek(input logic sel, output logic [7:0] val);
    hostSel = sel;
    #1 val = hostRdata;
  endtask

  // counts cycles busy stays high, starting at the current negedge
  task automatic busyLen(output int n);
    logic [7:0] v;
    n = 0;
    peek(1'b0, v);
    while (v[7] && n < 50) begin
      n++;
      @(negedge clk);
      peek(1'b0, v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state of both host registers
    peek(1'b0, v); chk("R1 ctrl", v, 8'h00);
    peek(1'b1, v); chk("R1 data", v, 8'h00);

    // R1 every slot zero; short reads, R5 short width, R7 address step
    for (int i = 0; i < 16; i++) begin
      wrReg(1'b0, 8'h90 | 8'(i));
      busyLen(n);
      chk("R5 short read width", n, 1);
      peek(1'b1, v); chk("R1 slot zero", v, 0);
      peek(1'b0, v); chk("R7 addr after read", v, 8'h10 | 8'(nextAddr(i)));
    end

    // R2 field layout and readback including the spare bit
    wrReg(1'b0, 8'h2A);
    peek(1'b0, v); chk("R2 readback", v, 8'h2A);
    peek(1'b0, v); chk("R2 busy idle", v[7], 0);

    // R4 writes, alternating widths; spare bit set on short ones (R2 no effect)
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c;
      c = ((i % 2) == 1) ? (8'h30 | 8'(i)) : 8'(i);
      wrReg(1'b0, c);
      wrReg(1'b1, pat(i));
      busyLen(n);
      chk(((i % 2) == 1) ? "R5 short write width R2" : "R5 long write width", n,
          ((i % 2) == 1) ? 1 : 4);
      peek(1'b1, v); chk("R4 data window holds write", v, pat(i));
      peek(1'b0, v); chk("R7 addr after write", v[3:0], nextAddr(i));
    end

    // R3 R9 long readback of every slot
    for (int i = 0; i < 16; i++) begin
      wrReg(1'b0, 8'h80 | 8'(i));
      busyLen(n);
      chk("R5 long read width", n, 4);
      peek(1'b1, v); chk("R3 R9 readback", v, pat(i));
    end

    // R6 auto-read chain across the capture group and past its end (R7)
    wrReg(1'b0, 8'hC0);
    busyLen(n);
    for (int k = 0; k < 8; k++) begin
      rdReg(1'b1, v);
      chk("R6 chained value", v, pat(k < 6 ? k : 6));
      peek(1'b0, v); chk("R6 read started", v[7], 1);
      busyLen(n);
    end
    peek(1'b0, v); chk("R7 stops at slot 6", v[3:0], 6);

    // R6 auto-read off: data read starts nothing
    wrReg(1'b0, 8'h03);
    rdReg(1'b1, v);
    peek(1'b0, v); chk("R6 no auto start", v, 8'h03);
    @(negedge clk);
    peek(1'b0, v); chk("R6 still idle", v[7], 0);

    // R8 writes during a long transfer are ignored
    wrReg(1'b0, 8'h02);
    wrReg(1'b1, 8'hAA);
    wrReg(1'b1, 8'h55);
    wrReg(1'b0, 8'h9C);
    busyLen(n);
    peek(1'b1, v); chk("R8 data kept", v, 8'hAA);
    peek(1'b0, v); chk("R8 ctrl kept", v, 8'h03);
    wrReg(1'b0, 8'h82);
    busyLen(n);
    peek(1'b1, v); chk("R8 slot holds first write", v, 8'hAA);

    // R7 alarm group end: 13 steps to 14, 14 stays
    wrReg(1'b0, 8'h9D);
    busyLen(n);
    peek(1'b0, v); chk("R7 13 to 14", v[3:0], 14);
    wrReg(1'b0, 8'h9E);
    busyLen(n);
    peek(1'b0, v); chk("R7 14 holds", v[3:0], 14);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule